// File: doc/BRIEF.md
# Dual-Channel Buffered PWM Timer with Shared Period

The block drives two PWM channels from a single up-counter. The first channel is the master. Its compare register A sets the period: when the counter reaches that value, the counter returns to zero on the next edge. Each channel holds four compare registers, A, B, C and D, and has one PWM pin and one sticky match flag per register. Registers C and D can serve as staging buffers for A and B. The mode bits of the master channel alone choose this buffering, and the choice applies to both channels together.

Software loads new duty values into C and D at any point in a period. At the period match, every staged value moves into its active register on the same edge that clears the counter. The new duties therefore start with the next period. While a register serves as a buffer, it raises no match flag and its pin stays low. The slave channel keeps its own mode bits. Its low mode bit only switches off its C pin.

Top module: `pwm_pair_buf`

## Requirements
- R1: After reset the counter, every compare register, both mode fields, all eight flags and all eight PWM outputs are zero.
- R2: While `run_i` is high, the counter adds one per cycle. On the cycle after it equals master register A, it reads zero instead. While `run_i` is low, the counter holds its value and no match, flag or PWM edge occurs.
- R3: Writes use `wr_addr_i[3]` to select the channel (0 = master, 1 = slave) and `wr_addr_i[2:0]` to select the field: 0 mode, 1 A, 2 B, 3 C, 4 D, 5 flag clear. Field codes 6 and 7 do nothing. In the mode field, bit 0 selects C-buffers-A and bit 1 selects D-buffers-B. Only the master's mode field decides buffering, and it decides it for both channels. The slave's mode bits never make a slave register a buffer.
- R4: On the edge where the counter clears, C is copied into A in both channels when the master's bit 0 is set, and D is copied into B when the master's bit 1 is set. If C is written in that same cycle, the old C value is transferred and the new value waits for the next period.
- R5: A write to C or D never changes an active register mid-period. A write to A or B takes effect on the next edge, and it wins over a transfer in the same cycle.
- R6: Flag bit `ch*4+k` (k: A=0, B=1, C=2, D=3) sets on the edge after the running counter equals that register. It stays set until it is cleared.
- R7: A C or D register that is serving as a buffer never sets its flag, even when the counter equals its value.
- R8: A write to field 5 of a channel clears flag k of that channel wherever `wr_data_i[k]` is 0. A flag that sets in the same cycle stays set.
- R9: For each pin, the rules below apply in order of priority. A register value of zero forces the pin low. A period match drives it high. A match with its own register drives it low. Otherwise the pin holds. Each pin changes on the edge after the event.
- R10: A pin whose C or D register is serving as a buffer is held low. The slave's C pin is also held low while the slave's own mode bit 0 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_i | input | 1 | Counter run enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Channel (bit 3) and field (bits 2:0) |
| wr_data_i | input | CNT_W | Write data |
| cnt_o | output | CNT_W | Shared counter value |
| flag_o | output | 8 | Sticky match flags, index ch*4+k |
| pwm_o | output | 8 | PWM pins, index ch*4+k |

## Verification
Two events can fall in the same cycle: the period transfer and a software write to the very register being transferred (C written, or A written, on the wrap cycle). A flag being set can also coincide with a clear of that flag. The bench tracks the counter in its model, drives the write on exactly the cycle where the model predicts a wrap, and judges the outcome by the length of the following two periods and by the pin edges. Random traffic with a fixed seed also lands flag clears on match cycles, and every cycle is compared against the bench's model.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
  localparam int NCH    = 2;
  localparam int NREG   = 4;
  localparam int FLD_W  = 3;
  localparam int ADDR_W = FLD_W + 1;

  localparam int IDX_A = 0;
  localparam int IDX_B = 1;
  localparam int IDX_C = 2;
  localparam int IDX_D = 3;

  typedef enum logic [FLD_W-1:0] {
    F_MODE = 3'd0,
    F_CMPA = 3'd1,
    F_CMPB = 3'd2,
    F_CMPC = 3'd3,
    F_CMPD = 3'd4,
    F_FCLR = 3'd5
  } field_e;
endpackage

// File: rtl/pwm_pair_rst_sync.sv
module pwm_pair_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/pwm_pair_cnt.sv
module pwm_pair_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign wrap_o = run_i && (cnt_q == period_i);

  always_comb begin : cnt_next
    cnt_en = run_i;
    cnt_d  = wrap_o ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R2
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (cnt_q == '0));
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !wrap_o) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> $stable(cnt_q));
endmodule

// File: rtl/pwm_pair_chan.sv
module pwm_pair_chan
  import pwm_pair_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter bit IS_SLAVE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             wrap_i,
  input  logic             buf_ac_i,
  input  logic             buf_bd_i,
  input  logic             wr_sel_i,
  input  field_e           wr_field_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [1:0]       mode_o,
  output logic [CNT_W-1:0] cmp_a_o,
  output logic [NREG-1:0]  flag_o,
  output logic [NREG-1:0]  pwm_o
);
  logic [CNT_W-1:0] cmp_q [NREG];
  logic [CNT_W-1:0] cmp_d [NREG];
  logic [NREG-1:0]  cmp_en;
  logic [1:0]       mode_q, mode_d;
  logic             mode_en;
  logic [NREG-1:0]  flag_q, flag_d, set_v, clr_v;
  logic             flag_en;
  logic [NREG-1:0]  pwm_q, pwm_d;
  logic [NREG-1:0]  hit, is_buf, kill;
  logic             slave_c_off;
  logic             wr_a;

  assign wr_a = wr_sel_i && (wr_field_i == F_CMPA);

  generate
    if (IS_SLAVE) begin : g_slave
      assign slave_c_off = mode_q[0];
    end else begin : g_master
      assign slave_c_off = 1'b0;
    end
  endgenerate

  // compare registers: transfer first, direct write overrides
  always_comb begin : cmp_next
    for (int k = 0; k < NREG; k++) begin
      cmp_d[k]  = cmp_q[k];
      cmp_en[k] = 1'b0;
    end
    if (wrap_i && buf_ac_i) begin
      cmp_d[IDX_A]  = cmp_q[IDX_C];
      cmp_en[IDX_A] = 1'b1;
    end
    if (wrap_i && buf_bd_i) begin
      cmp_d[IDX_B]  = cmp_q[IDX_D];
      cmp_en[IDX_B] = 1'b1;
    end
    if (wr_sel_i) begin
      case (wr_field_i)
        F_CMPA: begin cmp_d[IDX_A] = wr_data_i; cmp_en[IDX_A] = 1'b1; end
        F_CMPB: begin cmp_d[IDX_B] = wr_data_i; cmp_en[IDX_B] = 1'b1; end
        F_CMPC: begin cmp_d[IDX_C] = wr_data_i; cmp_en[IDX_C] = 1'b1; end
        F_CMPD: begin cmp_d[IDX_D] = wr_data_i; cmp_en[IDX_D] = 1'b1; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NREG; k++) cmp_q[k] <= '0;
    end else begin
      for (int k = 0; k < NREG; k++)
        if (cmp_en[k]) cmp_q[k] <= cmp_d[k];
    end
  end

  always_comb begin : mode_next
    mode_en = wr_sel_i && (wr_field_i == F_MODE);
    mode_d  = wr_data_i[1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_en) mode_q <= mode_d;
  end

  // matches, flags and pins
  always_comb begin : evt_next
    for (int k = 0; k < NREG; k++)
      hit[k] = run_i && (cnt_i == cmp_q[k]);
    is_buf        = '0;
    is_buf[IDX_C] = buf_ac_i;
    is_buf[IDX_D] = buf_bd_i;
    kill          = is_buf;
    kill[IDX_C]   = is_buf[IDX_C] | slave_c_off;
    set_v   = hit & ~is_buf;
    clr_v   = (wr_sel_i && (wr_field_i == F_FCLR)) ? ~wr_data_i[NREG-1:0] : '0;
    flag_d  = (flag_q & ~clr_v) | set_v;
    flag_en = (|set_v) | (|clr_v);
    for (int k = 0; k < NREG; k++) begin
      if (kill[k])                 pwm_d[k] = 1'b0;
      else if (cmp_q[k] == '0)     pwm_d[k] = 1'b0;
      else if (wrap_i)             pwm_d[k] = 1'b1;
      else if (hit[k])             pwm_d[k] = 1'b0;
      else                         pwm_d[k] = pwm_q[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= '0;
    else if (flag_en) flag_q <= flag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= '0;
    else        pwm_q <= pwm_d;
  end

  assign mode_o  = mode_q;
  assign cmp_a_o = cmp_q[IDX_A];
  assign flag_o  = flag_q;
  assign pwm_o   = pwm_q;

  // R7
  buf_c_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_ac_i && !flag_q[IDX_C]) |=> !flag_q[IDX_C]);
  // R7
  buf_d_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_bd_i && !flag_q[IDX_D]) |=> !flag_q[IDX_D]);
  // R4
  xfer_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_i && buf_ac_i && !wr_a) |=> (cmp_q[IDX_A] == $past(cmp_q[IDX_C])));
  // R5
  hold_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap_i && !wr_a) |=> $stable(cmp_q[IDX_A]));
  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[IDX_B] && !clr_v[IDX_B]) |=> flag_q[IDX_B]);
  // R10
  c_pin_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill[IDX_C] |=> !pwm_q[IDX_C]);
  // R9
  zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_q[IDX_B] == '0) |=> !pwm_q[IDX_B]);
endmodule

// File: rtl/pwm_pair_buf.sv
module pwm_pair_buf
  import pwm_pair_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run_i,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [CNT_W-1:0]     wr_data_i,
  output logic [CNT_W-1:0]     cnt_o,
  output logic [NCH*NREG-1:0]  flag_o,
  output logic [NCH*NREG-1:0]  pwm_o
);
  logic             rst_int_n;
  logic             wrap;
  field_e           fld;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       mode_w  [NCH];
  logic [CNT_W-1:0] cmpa_w  [NCH];
  logic [NCH-1:0]   ch_sel;
  logic [CNT_W+1:0] spare_unused;

  pwm_pair_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign fld = field_e'(wr_addr_i[FLD_W-1:0]);

  pwm_pair_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .run_i    (run_i),
    .period_i (cmpa_w[0]),
    .cnt_o    (cnt),
    .wrap_o   (wrap)
  );

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      assign ch_sel[g] = wr_en_i && (wr_addr_i[ADDR_W-1] == g[0]);
      pwm_pair_chan #(.CNT_W(CNT_W), .IS_SLAVE(g != 0)) u_chan (
        .clk        (clk),
        .rst_n      (rst_int_n),
        .run_i      (run_i),
        .wrap_i     (wrap),
        .buf_ac_i   (mode_w[0][0]),
        .buf_bd_i   (mode_w[0][1]),
        .wr_sel_i   (ch_sel[g]),
        .wr_field_i (fld),
        .wr_data_i  (wr_data_i),
        .cnt_i      (cnt),
        .mode_o     (mode_w[g]),
        .cmp_a_o    (cmpa_w[g]),
        .flag_o     (flag_o[g*NREG +: NREG]),
        .pwm_o      (pwm_o[g*NREG +: NREG])
      );
    end
  endgenerate

  assign spare_unused = {mode_w[1], cmpa_w[1]};
  assign cnt_o        = cnt;

  // R3
  one_chan_sel_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(ch_sel));
endmodule

// File: tb/pwm_pair_buf_tb_top.sv
module pwm_pair_buf_tb_top;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          run_i;
  logic          wr_en_i;
  logic [3:0]    wr_addr_i;
  logic [CW-1:0] wr_data_i;
  logic [CW-1:0] cnt_o;
  logic [7:0]    flag_o;
  logic [7:0]    pwm_o;

  pwm_pair_buf #(.CNT_W(CW)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .cnt_o     (cnt_o),
    .flag_o    (flag_o),
    .pwm_o     (pwm_o)
  );

  always #5 clk = ~clk;

  logic [CW-1:0] m_cmp [2][4];
  logic [1:0]    m_mode [2];
  logic [7:0]    m_flag, m_pwm;
  logic [CW-1:0] m_cnt;
  int    n_run = 0, n_fail = 0, wd = 0;
  bit    done = 0;
  string ctag = "R2", ftag = "R6", ptag = "R9";

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      n_fail++;
      $display("FAIL R2 watchdog actual=%0d expected=<150000", wd);
      finish_run();
    end
  end

  // one cycle: drive, predict from the requirements, compare after the edge
  task automatic step(input bit run, input bit we, input logic [3:0] addr,
                      input logic [CW-1:0] data);
    logic [CW-1:0] nc [2][4];
    logic [1:0]    nm [2];
    logic [7:0]    nf, np;
    logic [CW-1:0] ncnt;
    bit wrap, hit, isb, kill, clr;
    int ch, f, idx;
    run_i = run; wr_en_i = we; wr_addr_i = addr; wr_data_i = data;
    ch = int'(addr[3]); f = int'(addr[2:0]);
    wrap = run && (m_cnt == m_cmp[0][0]);
    for (int c = 0; c < 2; c++) begin
      for (int k = 0; k < 4; k++) begin
        idx  = c*4 + k;
        hit  = run && (m_cnt == m_cmp[c][k]);
        isb  = (k == 2 && m_mode[0][0]) || (k == 3 && m_mode[0][1]);
        kill = isb || (c == 1 && k == 2 && m_mode[1][0]);
        clr  = we && ch == c && f == 5 && !data[k];
        nf[idx] = (m_flag[idx] && !clr) || (hit && !isb);
        if (kill)                   np[idx] = 1'b0;
        else if (m_cmp[c][k] == 0)  np[idx] = 1'b0;
        else if (wrap)              np[idx] = 1'b1;
        else if (hit)               np[idx] = 1'b0;
        else                        np[idx] = m_pwm[idx];
        nc[c][k] = m_cmp[c][k];
      end
      nm[c] = m_mode[c];
      if (wrap && m_mode[0][0]) nc[c][0] = m_cmp[c][2];
      if (wrap && m_mode[0][1]) nc[c][1] = m_cmp[c][3];
    end
    if (we) begin
      if (f == 0) nm[ch] = data[1:0];
      else if (f >= 1 && f <= 4) nc[ch][f-1] = data;
    end
    ncnt = run ? (wrap ? '0 : m_cnt + 1'b1) : m_cnt;
    @(posedge clk);
    @(negedge clk);
    m_cmp = nc; m_mode = nm; m_flag = nf; m_pwm = np; m_cnt = ncnt;
    check(cnt_o == m_cnt, ctag, "counter", int'(cnt_o), int'(m_cnt));
    check(flag_o == m_flag, ftag, "flags", int'(flag_o), int'(m_flag));
    check(pwm_o == m_pwm, ptag, "pwm", int'(pwm_o), int'(m_pwm));
  endtask

  task automatic wr(input int ch, input int f, input int v);
    step(1'b0, 1'b1, {ch[0], f[2:0]}, v[CW-1:0]);
  endtask

  task automatic runn(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 4'd0, '0);
  endtask

  initial begin
    rst_n = 1'b0; run_i = 0; wr_en_i = 0; wr_addr_i = 0; wr_data_i = 0;
    for (int c = 0; c < 2; c++) begin
      m_mode[c] = 0;
      for (int k = 0; k < 4; k++) m_cmp[c][k] = 0;
    end
    m_flag = 0; m_pwm = 0; m_cnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cnt_o == 0, "R1", "counter after reset", int'(cnt_o), 0);
    check(flag_o == 0, "R1", "flags after reset", int'(flag_o), 0);
    check(pwm_o == 0, "R1", "pwm after reset", int'(pwm_o), 0);

    // R2 counting, wrap, hold
    ctag = "R2";
    wr(0, 1, 5); wr(0, 2, 3); wr(1, 2, 2);
    runn(14);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 4'd0, '0);
    runn(4);

    // R6 unbuffered C/D compare and set flags, R8 clears
    ftag = "R6";
    wr(0, 3, 2); wr(0, 4, 4); wr(1, 3, 1); wr(1, 4, 3);
    runn(12);
    ftag = "R8";
    wr(0, 5, 0); wr(1, 5, 4'b1010);
    runn(3);
    while (m_cnt != 2) runn(1);
    step(1'b1, 1'b1, {1'b0, 3'd5}, '0);   // clear during a C match: set wins
    runn(2);

    // R3/R7: master buffering applies to both channels
    ftag = "R7"; ptag = "R10";
    wr(0, 0, 3); wr(0, 5, 0); wr(1, 5, 0);
    runn(20);
    // R3: slave mode bits make no buffers
    ftag = "R3";
    wr(0, 0, 0); wr(1, 0, 2); wr(1, 5, 0);
    runn(15);

    // R10 slave C pin off by its own bit 0
    ptag = "R10";
    wr(1, 0, 1); wr(1, 3, 3);
    runn(15);
    wr(1, 0, 0);
    runn(10);

    // R4 write to C on the wrap cycle; R5 mid-period staging
    ctag = "R4"; ptag = "R4"; ftag = "R4";
    wr(0, 0, 1); wr(0, 3, 4); wr(1, 3, 2);
    runn(1);
    while (m_cnt != m_cmp[0][0]) runn(1);
    step(1'b1, 1'b1, {1'b0, 3'd3}, 8'd9);
    runn(20);
    ctag = "R5"; ptag = "R5";
    while (m_cnt != 1) runn(1);
    step(1'b1, 1'b1, {1'b0, 3'd3}, 8'd3);
    runn(25);
    // R5 direct A write on the wrap cycle wins over transfer
    while (m_cnt != m_cmp[0][0]) runn(1);
    step(1'b1, 1'b1, {1'b0, 3'd1}, 8'd7);
    runn(20);

    // R9 zero compare keeps the pin low
    ctag = "R2"; ftag = "R6"; ptag = "R9";
    wr(0, 0, 0); wr(0, 2, 0); wr(1, 1, 0);
    runn(12);

    // constrained random traffic
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 4000; i++) begin
      bit run, we;
      int ch, f, v;
      run = ($urandom_range(0, 9) != 0);
      we  = ($urandom_range(0, 9) < 3);
      ch  = $urandom_range(0, 1);
      f   = $urandom_range(0, 7);
      if (f == 0)      v = $urandom_range(0, 3);
      else if (f == 5) v = $urandom_range(0, 15);
      else             v = $urandom_range(0, 24);
      if (f == 1 && ch == 0 && v < 2) v = 2;
      step(run, we, {ch[0], f[2:0]}, v[CW-1:0]);
    end
    finish_run();
  end
endmodule